// File: doc/BRIEF.md
# Timer Count-Enable Source Selector

This block decides, on every system clock, whether an 8-bit timer advances. A 3-bit select input chooses among eight sources: stopped, every clock, four fixed divisions of the system clock, and the falling or rising edges of an external pin. The result is a single-cycle enable pulse, `tick`, which the timer uses as its count enable. The counter itself lives outside this block.

A free-running 10-bit prescaler counts system clocks from reset and supplies the divided rates. The external pin goes through a two-flop synchronizer. Its edges are found by comparing the synchronized level with the level one clock earlier. The pin is sampled whatever drives it, so the timer can be stepped by toggling a pin that is configured as an output. `tick` comes from a register, so changing the select produces no glitch pulse.

Top module: `tmr_clk_sel`

## Requirements
- R1: While `rst_n` is low, `tick` is 0. The prescaler restarts from zero when reset is released.
- R2: Select 3'b000 stops the timer: `tick` stays 0.
- R3: Select 3'b001 gives a `tick` of 1 after every clock edge.
- R4: Selects 3'b010, 3'b011, 3'b100 and 3'b101 give a divide-by-8, -64, -256 and -1024 enable. Counting k as the rising edges since reset release, `tick` is 1 just after edge k exactly when k is a nonzero multiple of the division.
- R5: Select 3'b110 counts falling edges of `ext_pin`. A pin value first applied before edge j produces `tick` just after edge j+2, as one single-cycle pulse.
- R6: Select 3'b111 counts rising edges of `ext_pin`, with the same three-edge latency and single-cycle pulse as R5.
- R7: A pin transition of the polarity that is not selected gives no `tick`. In the stopped, every-clock and prescaled selects, `ext_pin` has no effect on `tick`.
- R8: A new select value is applied at the next clock edge. The prescaler keeps running under every select, so the prescaled pulses stay aligned to the count of edges since reset, whatever the select history.
- R9: A pin level held for at least two system clocks yields exactly one pulse per selected edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 3 | Count source select |
| ext_pin | input | 1 | External count pin, asynchronous |
| tick | output | 1 | Single-cycle timer count enable |

## Verification
Each internal select is run from a fresh reset for more than one full prescaler period. Meanwhile `ext_pin` toggles, so a wrong tap, an off-by-one phase or any leak of the pin into those modes shows up as a pulse in the wrong cycle. The two edge selects are driven with pin pulses whose widths run from two clocks upward. This separates the falling polarity from the rising one, checks the three-edge latency, and rules out double counting. A final run changes the select in the middle of counting. It shows whether the prescaler phase survives stopped periods and whether a new select is applied on the very next edge.

// File: rtl/tmr_clk_sel.sv
`timescale 1ns/1ps
module tmr_clk_sel #(
  parameter int PRE_W = 10,
  parameter int TAP_A = 3,
  parameter int TAP_B = 6,
  parameter int TAP_C = 8,
  parameter int TAP_D = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       ext_pin,
  output logic       tick
);
  localparam logic [PRE_W-1:0] MASK_A = {PRE_W{1'b1}} >> (PRE_W - TAP_A);
  localparam logic [PRE_W-1:0] MASK_B = {PRE_W{1'b1}} >> (PRE_W - TAP_B);
  localparam logic [PRE_W-1:0] MASK_C = {PRE_W{1'b1}} >> (PRE_W - TAP_C);
  localparam logic [PRE_W-1:0] MASK_D = {PRE_W{1'b1}} >> (PRE_W - TAP_D);

  logic [PRE_W-1:0] pre;
  logic [2:0]       pin_q;
  logic             rise, fall, en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_q <= '0;
    else        pin_q <= {pin_q[1:0], ext_pin};

  assign rise =  pin_q[1] & ~pin_q[2];
  assign fall = ~pin_q[1] &  pin_q[2];

  always_comb begin
    case (sel)
      3'd1:    en = 1'b1;
      3'd2:    en = (pre & MASK_A) == MASK_A;
      3'd3:    en = (pre & MASK_B) == MASK_B;
      3'd4:    en = (pre & MASK_C) == MASK_C;
      3'd5:    en = (pre & MASK_D) == MASK_D;
      3'd6:    en = fall;
      3'd7:    en = rise;
      default: en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tick <= 1'b0;
    else        tick <= en;
endmodule

module tmr_clk_sel_chk #(
  parameter int PRE_W = 10,
  parameter int TAP_A = 3,
  parameter int TAP_B = 6,
  parameter int TAP_C = 8,
  parameter int TAP_D = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] sel,
  input logic       tick
);
  logic [PRE_W-1:0] cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;

  assert_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 3'd0 |=> !tick);
  assert_every_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 3'd1 |=> tick);
  assert_div_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 3'd2 |=> tick == (cnt[TAP_A-1:0] == '0));
  assert_div_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 3'd3 |=> tick == (cnt[TAP_B-1:0] == '0));
  assert_div_c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 3'd4 |=> tick == (cnt[TAP_C-1:0] == '0));
  assert_div_d_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 3'd5 |=> tick == (cnt[TAP_D-1:0] == '0));
  assert_ext_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[2:1] == 2'b11 && $past(sel) == sel && tick) |=> !tick);
endmodule

bind tmr_clk_sel tmr_clk_sel_chk #(
  .PRE_W(PRE_W), .TAP_A(TAP_A), .TAP_B(TAP_B), .TAP_C(TAP_C), .TAP_D(TAP_D)
) u_chk (.clk(clk), .rst_n(rst_n), .sel(sel), .tick(tick));

// File: tb/tmr_clk_sel_tb.sv
`timescale 1ns/1ps
module tmr_clk_sel_tb;
  logic clk = 1'b0, rst_n = 1'b0, ext_pin = 1'b0;
  logic [2:0] sel = 3'd0;
  logic tick;
  int checks = 0, failures = 0;
  int n = 0;
  logic h1 = 1'b0, h2 = 1'b0, h3 = 1'b0;
  bit done = 1'b0;

  tmr_clk_sel u_dut (.clk(clk), .rst_n(rst_n), .sel(sel), .ext_pin(ext_pin), .tick(tick));

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cycle=%0d sel=%0d tick=%0b expected=%0b", req, n, sel, act, exp);
    end
  endtask

  task automatic step(input string req);
    logic exp;
    int k;
    @(posedge clk);
    k = n + 1;
    case (sel)
      3'd1: exp = 1'b1;
      3'd2: exp = (k % 8) == 0;
      3'd3: exp = (k % 64) == 0;
      3'd4: exp = (k % 256) == 0;
      3'd5: exp = (k % 1024) == 0;
      3'd6: exp = ~h2 & h3;
      3'd7: exp = h2 & ~h3;
      default: exp = 1'b0;
    endcase
    h3 = h2; h2 = h1; h1 = ext_pin;
    n = k;
    @(negedge clk);
    check(tick === exp, req, tick, exp);
  endtask

  task automatic do_reset(input logic [2:0] s);
    @(negedge clk);
    rst_n = 1'b0; sel = s; ext_pin = 1'b0;
    repeat (3) @(negedge clk);
    check(tick === 1'b0, "R1", tick, 1'b0);
    rst_n = 1'b1;
    n = 0; h1 = 1'b0; h2 = 1'b0; h3 = 1'b0;
  endtask

  task automatic pin_widths(input string req);
    for (int w = 2; w <= 9; w++) begin
      ext_pin = ~ext_pin;
      repeat (w) step(req);
    end
  endtask

  initial begin
    for (int s = 0; s < 6; s++) begin
      do_reset(3'(s));
      for (int i = 0; i < 2100; i++) begin
        step(s == 0 ? "R2" : (s == 1 ? "R3" : "R4_R7"));
        ext_pin = ((i / 3) % 2) == 1;
      end
    end
    do_reset(3'd6);
    repeat (3) pin_widths("R5_R9");
    repeat (4) step("R5");
    do_reset(3'd7);
    repeat (3) pin_widths("R6_R9");
    repeat (4) step("R6");
    do_reset(3'd0);
    repeat (100) step("R8");
    sel = 3'd3; repeat (200) step("R8");
    sel = 3'd1; repeat (5) step("R8");
    sel = 3'd7; pin_widths("R8_R7");
    sel = 3'd0; repeat (37) step("R8");
    sel = 3'd2; repeat (40) step("R8");
    sel = 3'd6; pin_widths("R8_R7");
    sel = 3'd5; repeat (1100) step("R8");
    sel = 3'd4; repeat (600) step("R8");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired cycle=%0d", n);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule